// File: doc/BRIEF.md
# Serial Video Word Encoder

This block converts a stream of 10-bit parallel video words into a single serial bit stream for a serial digital video link. It runs on a fast clock with a bit-rate enable supplied from outside. A word is sampled on every tenth enabled cycle and shifted out one bit per enabled cycle, least significant bit first. Each serial bit then passes through a self-synchronizing scrambler with polynomial x^9 + x^4 + 1, followed by an NRZ-to-NRZI line coder. A bypass input sends the raw serializer output straight to the line for transparent data.

A small detector watches the sampled words for the three-word timing reference (all ones, then two all-zero words) and raises a flag. A disable input suppresses the flag. For 8-bit sources, the byte sits on the upper eight bits of the input bus. The two low bits are replaced so that an all-ones byte becomes the 10-bit all-ones word. A lock indication rises a fixed, parameterized number of clock cycles after reset. The reset input is taken as already synchronized to the clock.

Top module: `sdi_serial_encoder`

## Requirements
- R1: After reset, the first `bit_en` cycle samples `din`, and every tenth `bit_en` cycle after that samples the next word. Each sampled word leaves bit 0 first, over the ten `bit_en` cycles that follow its sampling. The bit sent on the sampling cycle of the very first word is 0.
- R2: The serializer, scrambler, line coder and `sdo` change only on cycles with `bit_en` high. `sdo_vld` is high for exactly one cycle after each `bit_en` cycle. In the cycle after a cycle with `bit_en` low, `sdo_vld` is 0 and `sdo` holds its value.
- R3: In scrambled mode, each scrambled bit s equals the serial bit XOR the scrambled bits sent 4 and 9 scrambled-mode bits earlier. s is then shifted into the 9-bit scrambler history, which is cleared by reset.
- R4: In scrambled mode, the line level on `sdo` toggles for each scrambled 1 and holds for each scrambled 0. The line level is 0 after reset.
- R5: When `bypass` is 1 on a `bit_en` cycle, `sdo` takes the raw serial bit, and the scrambler history and NRZI level are left unchanged. This lets a receiver that skips the same bits decode the stream exactly.
- R6: When `mode8` is 1 at sampling, `din[1:0]` is ignored. The sampled word is {din[9:2], 2'b11} when din[9:2] is all ones, and {din[9:2], 2'b00} otherwise.
- R7: `sync_det` goes to 1 on the cycle after a word is sampled when that word and the previous one are 0x000 and the word before those is 0x3FF (values after R6 conditioning). It holds its value until the next sampling.
- R8: If `sync_dis` is 1 when the last word of a timing reference is sampled, `sync_det` is 0 for that word.
- R9: `lock` is 0 from reset until exactly `LOCK_CYCLES` clock edges after reset release, and is then 1 until the next reset.
- R10: While `rst_n` is low, `sdo`, `sdo_vld`, `sync_det` and `lock` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | Serial bit-rate enable, one pulse per output bit |
| din | input | 10 | Parallel video word |
| mode8 | input | 1 | Treat `din[9:2]` as an 8-bit word |
| bypass | input | 1 | Send raw serial bits, skipping scrambler and NRZI |
| sync_dis | input | 1 | Suppress timing-reference detection |
| sdo | output | 1 | Serial line output |
| sdo_vld | output | 1 | `sdo` carries a newly produced bit this cycle |
| sync_det | output | 1 | Timing reference seen at the last sampled word |
| lock | output | 1 | Reset-to-lock interval has elapsed |

## Verification
Assertions in the RTL check local cycle-level rules on every cycle. The bit counter stays in range and nothing moves without `bit_en`. Bypass passes the raw bit while freezing the scrambler and NRZI level. The line level relates to the newest scrambler bit. The sync flag is held between samplings and is forced low by the disable. Lock never drops once set. End-to-end properties can only be shown by the bench's scenarios: exact word recovery through a model descrambler and NRZI decoder, across scrambled and bypass stretches that switch mid-word. The same holds for 8-bit conditioning, timing references appearing or suppressed, and the exact lock cycle.

// File: rtl/sdi_enc_pkg.sv
package sdi_enc_pkg;
  localparam int unsigned WORD_W = 10;
  typedef logic [WORD_W-1:0] word_t;
  localparam word_t TRS_HI = '1;
  localparam word_t TRS_LO = '0;
  localparam int unsigned SCR_LEN = 9;
  localparam int unsigned SCR_TAP = 4;
endpackage

// File: rtl/sdi_word_cond.sv
module sdi_word_cond
  import sdi_enc_pkg::*;
(
  input  word_t din,
  input  logic  mode8,
  output word_t dout
);
  logic upper_ones;

  always_comb begin
    upper_ones = &din[WORD_W-1:2];
    if (mode8) dout = {din[WORD_W-1:2], {2{upper_ones}}};
    else       dout = din;
  end
endmodule

// File: rtl/sdi_sync_det.sv
module sdi_sync_det
  import sdi_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  word_t word_in,
  input  logic  dis,
  output logic  sync_det
);
  word_t hist1_q, hist2_q, hist1_n, hist2_n;
  logic  flag_q, flag_n;

  always_comb begin
    hist1_n = hist1_q;
    hist2_n = hist2_q;
    flag_n  = flag_q;
    if (ld) begin
      hist1_n = word_in;
      hist2_n = hist1_q;
      flag_n  = !dis && (hist2_q == TRS_HI) && (hist1_q == TRS_LO) &&
                (word_in == TRS_LO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist1_q <= '0;
      hist2_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      hist1_q <= hist1_n;
      hist2_q <= hist2_n;
      flag_q  <= flag_n;
    end
  end

  assign sync_det = flag_q;

  p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(sync_det));
  p_sync_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && dis) |=> !sync_det);
endmodule

// File: rtl/sdi_serializer.sv
module sdi_serializer
  import sdi_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_en,
  input  word_t word_in,
  output logic  ld,
  output logic  ser_bit
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  word_t            sh_q, sh_n;

  assign ld      = bit_en && (cnt_q == LAST);
  assign ser_bit = sh_q[0];

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    if (bit_en) begin
      if (cnt_q == LAST) begin
        cnt_n = '0;
        sh_n  = word_in;
      end else begin
        cnt_n = cnt_q + 1'b1;
        sh_n  = sh_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_no_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(cnt_q) && $stable(sh_q)));
endmodule

// File: rtl/sdi_line_coder.sv
module sdi_line_coder
  import sdi_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bypass,
  input  logic bit_in,
  output logic sdo,
  output logic sdo_vld
);
  logic [SCR_LEN-1:0] sr_q, sr_n;
  logic lvl_q, lvl_n, sdo_q, sdo_n, vld_q;
  logic scr_bit;

  always_comb begin
    scr_bit = bit_in ^ sr_q[SCR_TAP-1] ^ sr_q[SCR_LEN-1];
    sr_n    = sr_q;
    lvl_n   = lvl_q;
    sdo_n   = sdo_q;
    if (bit_en) begin
      if (bypass) begin
        sdo_n = bit_in;
      end else begin
        sr_n  = {sr_q[SCR_LEN-2:0], scr_bit};
        lvl_n = lvl_q ^ scr_bit;
        sdo_n = lvl_q ^ scr_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      lvl_q <= 1'b0;
      sdo_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      sr_q  <= sr_n;
      lvl_q <= lvl_n;
      sdo_q <= sdo_n;
      vld_q <= bit_en;
    end
  end

  assign sdo     = sdo_q;
  assign sdo_vld = vld_q;

  p_bypass_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bypass) |=> ($stable(sr_q) && $stable(lvl_q)));
  p_bypass_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bypass) |=> (sdo == $past(bit_in)));
  p_nrzi_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !bypass) |=> (sr_q[0] == (sdo ^ $past(lvl_q))));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(sdo) && !sdo_vld));
endmodule

// File: rtl/sdi_lock_timer.sv
module sdi_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic lock
);
  localparam int unsigned LC_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [LC_W-1:0] LC_END = LC_W'(LOCK_CYCLES - 1);

  logic [LC_W-1:0] cnt_q, cnt_n;
  logic lock_q, lock_n;

  always_comb begin
    cnt_n  = cnt_q;
    lock_n = lock_q;
    if (!lock_q) begin
      cnt_n  = cnt_q + 1'b1;
      lock_n = (cnt_q == LC_END);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      lock_q <= lock_n;
    end
  end

  assign lock = lock_q;

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  p_lock_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> (cnt_q < LC_W'(LOCK_CYCLES)));
endmodule

// File: rtl/sdi_serial_encoder.sv
module sdi_serial_encoder
  import sdi_enc_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic [9:0]  din,
  input  logic        mode8,
  input  logic        bypass,
  input  logic        sync_dis,
  output logic        sdo,
  output logic        sdo_vld,
  output logic        sync_det,
  output logic        lock
);
  word_t cond_word;
  logic  ld, ser_bit;

  sdi_word_cond u_cond (
    .din   (din),
    .mode8 (mode8),
    .dout  (cond_word)
  );

  sdi_sync_det u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld),
    .word_in  (cond_word),
    .dis      (sync_dis),
    .sync_det (sync_det)
  );

  sdi_serializer u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .word_in (cond_word),
    .ld      (ld),
    .ser_bit (ser_bit)
  );

  sdi_line_coder u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .bypass  (bypass),
    .bit_in  (ser_bit),
    .sdo     (sdo),
    .sdo_vld (sdo_vld)
  );

  sdi_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .lock  (lock)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!sdo && !sdo_vld && !sync_det && !lock));
endmodule

// File: tb/tb_sdi_serial_encoder.sv
module tb_sdi_serial_encoder;
  localparam int NW    = 200;
  localparam int NP    = NW * 10 + 1;
  localparam int LOCKC = 64;

  logic clk = 1'b0;
  logic rst_n, bit_en, mode8, bypass, sync_dis;
  logic [9:0] din;
  logic sdo, sdo_vld, sync_det, lock;

  always #2 clk = ~clk;

  sdi_serial_encoder #(.LOCK_CYCLES(LOCKC)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din), .mode8(mode8),
    .bypass(bypass), .sync_dis(sync_dis), .sdo(sdo), .sdo_vld(sdo_vld),
    .sync_det(sync_det), .lock(lock)
  );

  int vec = 0, bad = 0;
  bit done = 1'b0;
  logic [9:0] cw [NW];
  logic       dis_k [NW];
  logic       bmode [NP];

  // decoder model state
  logic       lvl_m;
  logic [8:0] r_m;
  logic [9:0] wb;

  function automatic logic [9:0] cond(input logic [9:0] d, input logic m8);
    if (!m8) return d;
    return {d[9:2], (&d[9:2]) ? 2'b11 : 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    int pulse, edges, prev_pulse, prev_k;
    bit prev_en, prev_load, last_sdo;
    sd = $urandom(32'h1F2E3D4C);
    rst_n = 1'b0; bit_en = 1'b0; din = '0; mode8 = 1'b0;
    bypass = 1'b0; sync_dis = 1'b0;
    lvl_m = 1'b0; r_m = '0; wb = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!sdo && !sdo_vld && !sync_det && !lock, "R10",
        {sdo, sdo_vld, sync_det, lock}, 0);
    rst_n = 1'b1;
    pulse = 0; edges = 0; prev_en = 0; prev_load = 0; prev_pulse = 0;
    prev_k = 0; last_sdo = 1'b0;
    while (!(pulse >= NP && !prev_en)) begin
      @(negedge clk);
      edges++;
      if (edges == LOCKC - 1) chk(lock == 1'b0, "R9 early", lock, 0);
      if (edges == LOCKC)     chk(lock == 1'b1, "R9 rise", lock, 1);
      if (prev_en) begin
        bit d, s;
        chk(sdo_vld == 1'b1, "R2 vld", sdo_vld, 1);
        if (bmode[prev_pulse]) d = sdo;
        else begin
          s = sdo ^ lvl_m;
          lvl_m = sdo;
          d = s ^ r_m[3] ^ r_m[8];
          r_m = {r_m[7:0], s};
        end
        if (prev_pulse == 0) chk(d == 1'b0, "R1 first bit", d, 0);
        else begin
          int j;
          j = prev_pulse - 1;
          wb[j % 10] = d;
          if (j % 10 == 9)
            chk(wb == cw[j / 10], "R1 R3 R4 R5 word", wb, cw[j / 10]);
        end
      end else if (pulse > 0) begin
        chk(sdo_vld == 1'b0 && sdo == last_sdo, "R2 idle",
            {sdo_vld, sdo}, {1'b0, last_sdo});
      end
      if (prev_load && prev_k < NW) begin
        bit e;
        e = (prev_k >= 2) && !dis_k[prev_k] && cw[prev_k-2] == 10'h3FF &&
            cw[prev_k-1] == 10'h000 && cw[prev_k] == 10'h000;
        chk(sync_det == e, "R7 R8 sync", sync_det, e);
      end
      last_sdo = sdo;
      // drive next cycle
      prev_load = 1'b0;
      prev_en = (pulse < NP) && ($urandom % 4 != 0);
      bit_en = prev_en;
      if (prev_en) begin
        if (pulse % 10 == 0) begin
          int k;
          k = pulse / 10;
          mode8 = 1'b0; sync_dis = 1'b0;
          case (k)
            3, 8:    din = 10'h3FF;
            4, 5, 9: din = 10'h000;
            10: begin din = 10'h000; sync_dis = 1'b1; end       // R8
            14: begin din = 10'h3FC; mode8 = 1'b1; end          // R6 -> 3FF
            15: begin din = 10'h003; mode8 = 1'b1; end          // R6 -> 000
            16: begin din = 10'h001; mode8 = 1'b1; end          // R6 -> 000
            20, 21, 22: din = 10'h3FF;
            default: begin
              din = 10'($urandom);
              mode8 = ($urandom % 4 == 0);
              sync_dis = ($urandom % 8 == 0);
            end
          endcase
          bypass = ((k / 25) % 2 == 1);
          if (k < NW) begin
            cw[k] = cond(din, mode8);
            dis_k[k] = sync_dis;
          end
          prev_load = 1'b1;
          prev_k = k;
        end
        bmode[pulse] = bypass;
        prev_pulse = pulse;
        pulse++;
      end
    end
    chk(lock == 1'b1, "R9 held", lock, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule